// File: doc/BRIEF.md
# PHY Management Register File

This block models the register bank of a gigabit Ethernet PHY as the MAC sees it through one 32-bit command register. Software writes a command word carrying an opcode, a 5-bit register number and 16 bits of data. The block performs the read or write against a 32-entry bank in which each entry is readable, writable, both or neither. It then reports completion, errors and an optional management-done interrupt cause.

Inside the bank, the control register also starts a link autonegotiation restart. That restart takes the link down and runs a delay counter whose length is a parameter (500 ms of a 125 MHz clock by default). The link comes back, together with the negotiation-complete flag, only when the counter expires. The link state drives the `link_up_o` output, and the same value shows in the link bit of the status register.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: When `cmd_we_i` is high at a clock edge, the command word is taken and fully handled at that edge. From the next cycle, `cmd_rdata_o` echoes the word with bit 28 (ready) set and bit 30 (error) holding the outcome. Bits [22:21] are the opcode (01 write, 10 read), [20:16] the register number and [15:0] the data.
- R2: A read of a readable entry returns its value in `cmd_rdata_o[15:0]`. After reset the values are: 0 = 0x1140, 1 = 0x794D, 2 = 0x0141, 4 = 0x0DE1, 5 = 0x01E0 and 10 = 0x3C00. Every other entry is zero.
- R3: A write to a writable entry (0, 4, 9, 16, 20) stores the data, and a later read returns it.
- R4: A write to an entry without write permission leaves that entry unchanged and sets the error bit. A read of an entry without read permission returns data 0 with the error bit set. The readable entries are 0 to 5, 9, 10, 16, 17 and 20. An opcode of 00 or 11 sets the error bit and changes nothing.
- R5: `mdac_int_o` is high for exactly the one cycle after a command whose bit 24 (interrupt enable) was set, and stays low after any other command.
- R6: A write to entry 0 with bit 12 (autoneg enable) and bit 9 (restart) both set drives `link_up_o` low from the next cycle. It also clears status bit 2 (link) and status bit 5 (negotiation complete).
- R7: `link_up_o`, status bit 2 and status bit 5 become 1 exactly `AN_DELAY` cycles after the restart edge, and not earlier.
- R8: A restart while the delay is still running reloads the full count.
- R9: A control write with restart set but autoneg enable clear leaves the link and the negotiation-complete bit unchanged.
- R10: Reset loads the default values and cancels a running delay. It takes the link state from `link_ext_i`, so the link is forced low if the external link is down during reset.
- R11: `link_up_o` always equals bit 2 of the status register as returned by a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_ext_i | input | 1 | External link present, sampled during reset |
| cmd_we_i | input | 1 | Write strobe for the command register |
| cmd_wdata_i | input | 32 | Command word written by the MAC |
| cmd_rdata_o | output | 32 | Command register contents after the last access |
| mdac_int_o | output | 1 | Management-done interrupt cause, one-cycle pulse |
| link_up_o | output | 1 | Link state, mirrored as the MAC status link bit |

## Verification
Command results, the error bit and the interrupt pulse are due one cycle after the edge that takes the command. The bench drives each word for one cycle and reads the result at the following falling edge. A link drop is also due one cycle after the restart. Link recovery is due exactly `AN_DELAY` edges after the restart edge, so the bench issues no commands during the wait and counts falling edges, checking the link one cycle before the deadline and again at it. Status readbacks are issued only where the counted schedule fixes the expected link and completion bits.

// File: rtl/pmr_pkg.sv
// Package: shared widths, command field positions, register numbers and
// the per-entry capability and reset-value tables of the PHY register bank.
// Assumes a 32-entry bank of 16-bit registers addressed by 5 bits.
package pmr_pkg;

    localparam int unsigned PMR_ADDR_W = 5;
    localparam int unsigned PMR_REG_W  = 16;
    localparam int unsigned PMR_CMD_W  = 32;

    // Command word field positions
    localparam int unsigned CMD_ADDR_LSB = 16;
    localparam int unsigned CMD_OP_LSB   = 21;
    localparam int unsigned CMD_INT_BIT  = 24;
    localparam int unsigned CMD_RDY_BIT  = 28;
    localparam int unsigned CMD_ERR_BIT  = 30;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_BAD   = 2'b11
    } pmr_op_e;

    // Register numbers
    localparam logic [PMR_ADDR_W-1:0] REG_CTRL  = 5'd0;
    localparam logic [PMR_ADDR_W-1:0] REG_STAT  = 5'd1;
    localparam logic [PMR_ADDR_W-1:0] REG_ID1   = 5'd2;
    localparam logic [PMR_ADDR_W-1:0] REG_ID2   = 5'd3;
    localparam logic [PMR_ADDR_W-1:0] REG_ADV   = 5'd4;
    localparam logic [PMR_ADDR_W-1:0] REG_LPA   = 5'd5;
    localparam logic [PMR_ADDR_W-1:0] REG_GCTRL = 5'd9;
    localparam logic [PMR_ADDR_W-1:0] REG_GSTAT = 5'd10;
    localparam logic [PMR_ADDR_W-1:0] REG_SCTRL = 5'd16;
    localparam logic [PMR_ADDR_W-1:0] REG_SSTAT = 5'd17;
    localparam logic [PMR_ADDR_W-1:0] REG_XCTRL = 5'd20;

    // Control and status bit positions
    localparam int unsigned CTRL_AN_EN  = 12;
    localparam int unsigned CTRL_AN_RST = 9;
    localparam int unsigned STAT_LINK   = 2;
    localparam int unsigned STAT_ANC    = 5;

    localparam logic [PMR_REG_W-1:0] STAT_DEFAULT = 16'h794D;

    // Entry may be written through the command register
    function automatic logic pmr_writable(input logic [PMR_ADDR_W-1:0] a);
        return (a == REG_CTRL) || (a == REG_ADV) || (a == REG_GCTRL) ||
               (a == REG_SCTRL) || (a == REG_XCTRL);
    endfunction

    // Entry may be read through the command register
    function automatic logic pmr_readable(input logic [PMR_ADDR_W-1:0] a);
        return pmr_writable(a) || (a == REG_STAT) || (a == REG_ID1) ||
               (a == REG_ID2) || (a == REG_LPA) || (a == REG_GSTAT) ||
               (a == REG_SSTAT);
    endfunction

    // Value of each entry after reset
    function automatic logic [PMR_REG_W-1:0] pmr_reset_value(input logic [PMR_ADDR_W-1:0] a);
        case (a)
            REG_CTRL:  return 16'h1140;
            REG_STAT:  return STAT_DEFAULT;
            REG_ID1:   return 16'h0141;
            REG_ADV:   return 16'h0DE1;
            REG_LPA:   return 16'h01E0;
            REG_GSTAT: return 16'h3C00;
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/pmr_cmd_decode.sv
// Command decoder: turns the opcode and register number of a taken command
// into read/write strobes, the permission checks and the error outcome.
// Purely combinational; assumes the strobe is valid for one cycle.
module pmr_cmd_decode
    import pmr_pkg::*;
#(
    parameter int unsigned ADDR_W = PMR_ADDR_W
) (
    input  logic              cmd_we,
    input  logic [1:0]        op_field,
    input  logic [ADDR_W-1:0] addr,
    output logic              do_write,
    output logic              do_read,
    output logic              rd_ok,
    output logic              err
);

    logic wr_ok;
    logic is_wr;
    logic is_rd;

    // Permission lookup and opcode classification
    always_comb begin
        wr_ok    = pmr_writable(PMR_ADDR_W'(addr));
        rd_ok    = pmr_readable(PMR_ADDR_W'(addr));
        is_wr    = (pmr_op_e'(op_field) == OP_WRITE);
        is_rd    = (pmr_op_e'(op_field) == OP_READ);
        do_write = cmd_we && is_wr && wr_ok;
        do_read  = cmd_we && is_rd;
        err      = !(is_wr || is_rd) || (is_wr && !wr_ok) || (is_rd && !rd_ok);
    end

endmodule

// File: rtl/pmr_regbank.sv
// Register bank: one flop row per writable entry, constants for read-only
// entries, and the status entry supplied from outside. Structure of each
// entry is picked at elaboration from the capability table.
module pmr_regbank
    import pmr_pkg::*;
#(
    parameter int unsigned ADDR_W = PMR_ADDR_W,
    parameter int unsigned REG_W  = PMR_REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [REG_W-1:0]  stat_value,
    output logic [REG_W-1:0]  rd_data
);

    localparam int unsigned NUM_REGS = 1 << ADDR_W;

    logic [NUM_REGS-1:0][REG_W-1:0] bank;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
        localparam logic [PMR_ADDR_W-1:0] IDX = PMR_ADDR_W'(i);
        if (IDX == REG_STAT) begin : g_stat
            assign bank[i] = stat_value;
        end else if (pmr_writable(IDX)) begin : g_rw
            logic [REG_W-1:0] q;
            // Holds one writable entry, loaded with its default in reset
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= REG_W'(pmr_reset_value(IDX));
                end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
                    q <= wr_data;
                end
            end
            assign bank[i] = q;
        end else begin : g_ro
            assign bank[i] = REG_W'(pmr_reset_value(IDX));
        end
    end

    assign rd_data = bank[rd_addr];

endmodule

// File: rtl/pmr_an_timer.sv
// Autonegotiation restart sequencer: a restart drops the link and clears
// the completion flag, then a down-counter of DELAY cycles brings both back.
// A restart while counting reloads the full count. Reset cancels counting
// and takes the link state from the external link input.
module pmr_an_timer #(
    parameter int unsigned DELAY = 62_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_ext_i,
    input  logic restart_i,
    output logic link_o,
    output logic done_o
);

    localparam int unsigned CNT_W = $clog2(DELAY + 1);

    logic [CNT_W-1:0] cnt;

    // Counts the restart delay and updates link and completion state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            link_o <= link_ext_i;
            done_o <= 1'b0;
        end else if (restart_i) begin
            cnt    <= CNT_W'(DELAY);
            link_o <= 1'b0;
            done_o <= 1'b0;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
                link_o <= 1'b1;
                done_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/phy_mgmt_regfile.sv
// Top level: single command register in front of the PHY register bank.
// A command is taken and completed at the edge where cmd_we_i is high; the
// result, ready and error bits show from the next cycle. Control writes
// with autoneg enable and restart start the link restart sequence.
module phy_mgmt_regfile
    import pmr_pkg::*;
#(
    parameter int unsigned AN_DELAY = 62_500_000,
    parameter int unsigned ADDR_W   = PMR_ADDR_W,
    parameter int unsigned REG_W    = PMR_REG_W,
    parameter int unsigned CMD_W    = PMR_CMD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_ext_i,
    input  logic             cmd_we_i,
    input  logic [CMD_W-1:0] cmd_wdata_i,
    output logic [CMD_W-1:0] cmd_rdata_o,
    output logic             mdac_int_o,
    output logic             link_up_o
);

    logic [ADDR_W-1:0] addr;
    logic [REG_W-1:0]  wdata;
    logic [1:0]        op_field;
    logic              do_write;
    logic              do_read;
    logic              rd_ok;
    logic              err;
    logic              restart;
    logic              an_done;
    logic [REG_W-1:0]  stat_value;
    logic [REG_W-1:0]  rd_data;
    logic [CMD_W-1:0]  cmd_next;
    logic [CMD_W-1:0]  cmd_q;
    logic              mdac_q;

    assign addr     = cmd_wdata_i[CMD_ADDR_LSB +: ADDR_W];
    assign wdata    = cmd_wdata_i[REG_W-1:0];
    assign op_field = cmd_wdata_i[CMD_OP_LSB +: 2];

    pmr_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .cmd_we   (cmd_we_i),
        .op_field (op_field),
        .addr     (addr),
        .do_write (do_write),
        .do_read  (do_read),
        .rd_ok    (rd_ok),
        .err      (err)
    );

    // Restart request: accepted control write with enable and restart bits
    assign restart = do_write && (addr == ADDR_W'(REG_CTRL)) &&
                     wdata[CTRL_AN_EN] && wdata[CTRL_AN_RST];

    pmr_an_timer #(.DELAY(AN_DELAY)) u_an (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_ext_i (link_ext_i),
        .restart_i  (restart),
        .link_o     (link_up_o),
        .done_o     (an_done)
    );

    // Status entry: fixed defaults with live link and completion bits
    always_comb begin
        stat_value            = REG_W'(STAT_DEFAULT);
        stat_value[STAT_LINK] = link_up_o;
        stat_value[STAT_ANC]  = an_done;
    end

    pmr_regbank #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (do_write),
        .wr_addr    (addr),
        .wr_data    (wdata),
        .rd_addr    (addr),
        .stat_value (stat_value),
        .rd_data    (rd_data)
    );

    // Completed command word: echo with ready, error and read data
    always_comb begin
        cmd_next              = cmd_wdata_i;
        cmd_next[CMD_RDY_BIT] = 1'b1;
        cmd_next[CMD_ERR_BIT] = err;
        if (do_read) begin
            cmd_next[REG_W-1:0] = rd_ok ? rd_data : '0;
        end
    end

    // Command register and management-done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            mdac_q <= 1'b0;
        end else begin
            if (cmd_we_i) begin
                cmd_q <= cmd_next;
            end
            mdac_q <= cmd_we_i && cmd_wdata_i[CMD_INT_BIT];
        end
    end

    assign cmd_rdata_o = cmd_q;
    assign mdac_int_o  = mdac_q;

endmodule

// File: rtl/pmr_checker.sv
// Checker: temporal properties of the command register, interrupt pulse
// and link restart sequence; attached to every top-level instance by bind.
module pmr_checker
    import pmr_pkg::*;
#(
    parameter int unsigned CMD_W = PMR_CMD_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_we_i,
    input logic [CMD_W-1:0] cmd_wdata_i,
    input logic [CMD_W-1:0] cmd_rdata_o,
    input logic             mdac_int_o,
    input logic             link_up_o,
    input logic             an_done
);

    logic is_wr;
    logic wr_denied;
    logic an_restart;

    // Independent view of the command word fields
    always_comb begin
        is_wr      = cmd_we_i && (cmd_wdata_i[CMD_OP_LSB +: 2] == 2'b01);
        wr_denied  = is_wr && !pmr_writable(cmd_wdata_i[CMD_ADDR_LSB +: PMR_ADDR_W]);
        an_restart = is_wr && (cmd_wdata_i[CMD_ADDR_LSB +: PMR_ADDR_W] == REG_CTRL) &&
                     cmd_wdata_i[CTRL_AN_EN] && cmd_wdata_i[CTRL_AN_RST];
    end

    AST_CMD_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we_i |=> cmd_rdata_o[CMD_RDY_BIT]); // R1

    AST_DENIED_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_denied |=> cmd_rdata_o[CMD_ERR_BIT]); // R4

    AST_INT_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we_i && cmd_wdata_i[CMD_INT_BIT]) |=> mdac_int_o); // R5

    AST_INT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_we_i && cmd_wdata_i[CMD_INT_BIT]) |=> !mdac_int_o); // R5

    AST_LINK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart |=> (!link_up_o && !an_done)); // R6

    AST_DONE_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        an_done |-> link_up_o); // R7

endmodule

bind phy_mgmt_regfile pmr_checker #(.CMD_W(CMD_W)) u_pmr_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_we_i    (cmd_we_i),
    .cmd_wdata_i (cmd_wdata_i),
    .cmd_rdata_o (cmd_rdata_o),
    .mdac_int_o  (mdac_int_o),
    .link_up_o   (link_up_o),
    .an_done     (an_done)
);

// File: tb/test_phy_mgmt_regfile.sv
// Bench: table of command words and expected command-register results,
// walked by one loop, then directed tests of the restart sequence,
// interrupt pulse and reset behaviour.
module test_phy_mgmt_regfile;

    localparam int unsigned DLY   = 20;
    localparam int unsigned NVEC  = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_ext = 1'b1;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        mdac_int;
    logic        link_up;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    phy_mgmt_regfile #(.AN_DELAY(DLY)) i_phy_mgmt_regfile (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_ext_i  (link_ext),
        .cmd_we_i    (cmd_we),
        .cmd_wdata_i (cmd_wdata),
        .cmd_rdata_o (cmd_rdata),
        .mdac_int_o  (mdac_int),
        .link_up_o   (link_up)
    );

    // {command word, expected command register afterwards}
    localparam logic [63:0] VEC [NVEC] = '{
        {32'h0040_0000, 32'h1040_1140},  // R2 control default
        {32'h0141_0000, 32'h1141_794D},  // R2 status default, with interrupt
        {32'h0042_0000, 32'h1042_0141},  // R2 ID1
        {32'h0044_0000, 32'h1044_0DE1},  // R2 advertisement
        {32'h0045_0000, 32'h1045_01E0},  // R2 partner ability
        {32'h004A_0000, 32'h104A_3C00},  // R2 1000BASE-T status
        {32'h0024_1234, 32'h1024_1234},  // R3 write advertisement
        {32'h0044_0000, 32'h1044_1234},  // R3 read back
        {32'h0030_ABCD, 32'h1030_ABCD},  // R3 write entry 16
        {32'h0050_0000, 32'h1050_ABCD},  // R3 read back
        {32'h0021_FFFF, 32'h5021_FFFF},  // R4 write to read-only status
        {32'h0041_0000, 32'h1041_794D},  // R4 status unchanged
        {32'h0122_0000, 32'h5122_0000},  // R4 write to read-only ID1
        {32'h0042_0000, 32'h1042_0141},  // R4 ID1 unchanged
        {32'h0043_0000, 32'h1043_0000},  // R2 ID2 zero
        {32'h0046_ABCD, 32'h5046_0000},  // R4 read of unreadable entry
        {32'h0060_0000, 32'h5060_0000},  // R4 invalid opcode
        {32'h0020_1000, 32'h1020_1000},  // R3 control without restart
        {32'h0040_0000, 32'h1040_1000},  // R3 control read back
        {32'h0041_0000, 32'h1041_794D}   // R9 link untouched
    };

    // Compares one value and logs a failure line
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Issues one command for a single cycle; returns at the next falling edge
    task automatic do_cmd(input logic [31:0] w);
        @(negedge clk);
        cmd_we    = 1'b1;
        cmd_wdata = w;
        @(negedge clk);
        cmd_we    = 1'b0;
    endtask

    // Holds reset for two edges with the given external link state
    task automatic apply_reset(input logic ext);
        @(negedge clk);
        link_ext = ext;
        rst_n    = 1'b0;
        repeat (2) @(negedge clk);
        rst_n    = 1'b1;
    endtask

    // Prints the summary line and ends the run
    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R1 watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        apply_reset(1'b1);
        check("R10 reset command reg", cmd_rdata, 32'h0);
        check("R10 reset interrupt", {31'b0, mdac_int}, 32'h0);
        check("R10 reset link up", {31'b0, link_up}, 32'h1);

        // Vector table
        for (int k = 0; k < NVEC; k++) begin
            do_cmd(VEC[k][63:32]);
            check($sformatf("R1 R2 R3 R4 vector %0d", k), cmd_rdata, VEC[k][31:0]);
            check($sformatf("R5 vector %0d interrupt", k), {31'b0, mdac_int},
                  {31'b0, VEC[k][32+24]});
        end

        // R6 / R7: restart drops link, recovers exactly DLY edges later
        do_cmd(32'h0020_1200);
        check("R1 restart write result", cmd_rdata, 32'h1020_1200);
        check("R6 link low after restart", {31'b0, link_up}, 32'h0);
        repeat (DLY - 1) @(negedge clk);
        check("R7 link still low one cycle early", {31'b0, link_up}, 32'h0);
        @(negedge clk);
        check("R7 link up at deadline", {31'b0, link_up}, 32'h1);
        do_cmd(32'h0041_0000);
        check("R7 R11 status link and complete", cmd_rdata, 32'h1041_796D);

        // R8: second restart reloads the count
        do_cmd(32'h0020_1200);
        do_cmd(32'h0041_0000);
        check("R6 R11 status during restart", cmd_rdata, 32'h1041_7949);
        repeat (8) @(negedge clk);
        do_cmd(32'h0020_1200);
        repeat (DLY - 1) @(negedge clk);
        check("R8 link low before reloaded deadline", {31'b0, link_up}, 32'h0);
        @(negedge clk);
        check("R8 link up at reloaded deadline", {31'b0, link_up}, 32'h1);

        // R9: restart without autoneg enable does nothing to the link
        do_cmd(32'h0020_0200);
        repeat (3) @(negedge clk);
        check("R9 link kept", {31'b0, link_up}, 32'h1);
        do_cmd(32'h0041_0000);
        check("R9 R11 status kept", cmd_rdata, 32'h1041_796D);

        // R5: interrupt is a single-cycle pulse
        do_cmd(32'h0144_0000);
        check("R5 pulse high", {31'b0, mdac_int}, 32'h1);
        check("R2 R5 read with interrupt", cmd_rdata, 32'h1144_1234);
        @(negedge clk);
        check("R5 pulse ends", {31'b0, mdac_int}, 32'h0);

        // R10: reset during a running delay cancels it
        do_cmd(32'h0020_1200);
        apply_reset(1'b1);
        check("R10 link from external after reset", {31'b0, link_up}, 32'h1);
        repeat (DLY + 5) @(negedge clk);
        do_cmd(32'h0041_0000);
        check("R10 timer cancelled, status default", cmd_rdata, 32'h1041_794D);
        do_cmd(32'h0044_0000);
        check("R10 advertisement default restored", cmd_rdata, 32'h1044_0DE1);

        // R10: external link down at reset forces link low
        apply_reset(1'b0);
        check("R10 link low from external", {31'b0, link_up}, 32'h0);
        do_cmd(32'h0041_0000);
        check("R10 R11 status link low", cmd_rdata, 32'h1041_7949);
        do_cmd(32'h0020_1200);
        repeat (DLY) @(negedge clk);
        check("R7 link up after restart from down", {31'b0, link_up}, 32'h1);

        finish_run();
    end

endmodule